// File: doc/BRIEF.md
# Iterative AES-128 Block Cipher Engine

This engine encrypts or decrypts a single 128-bit block under a 128-bit key. All ten rounds run through one round datapath, one round per clock. Multiplexers steer that datapath between the forward and inverse transforms, depending on the mode sampled when a block is accepted.

A key is loaded with a one-cycle strobe. The engine then expands it into eleven round keys, one per cycle, and keeps them internally. Decryption walks these stored keys from the last to the first. Once `keyReady` is high, any number of blocks in either direction can be processed under that key without reloading it.

The block and key byte order is big-endian. Byte 0 sits in bits [127:120], and each group of four consecutive bytes forms one state column.

Top module: `aes_core`

## Requirements
- R1: After reset, `busy`, `done` and `keyReady` are all 0.
- R2: A `keyLoad` pulse accepted at one clock edge clears `keyReady`, and `keyReady` rises at the tenth rising edge after it. While `keyReady` is 0, a `start` pulse is ignored and `busy` stays 0.
- R3: With `decrypt`=0, the engine performs AES-128 encryption. Byte 0 is bits [127:120] and columns are 4 consecutive bytes, for both key and data. Key 000102…0f with input 00112233…eeff yields 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e1516…4f3c with input 3243f6a8…0734 yields 3925841d02dc09fbdc118597196a0b32.
- R4: With `decrypt`=1, the engine performs the inverse cipher, using the round keys in reverse order. Each R3 output decrypts back to its input.
- R5: When `start` is accepted at an edge, `busy` goes high. `done` is high for exactly one cycle, set at the tenth rising edge after the accepting edge, and `busy` falls at that same edge.
- R6: A `start` pulse while `busy` is 1 is ignored. The running block's result and its `done` timing are unchanged.
- R7: For any key and block x, decrypting the encryption of x returns x.
- R8: `blockOut` holds the result after `done` until the next accepted `start`.
- R9: A `keyLoad` pulse while `busy` is 1 is ignored. `keyReady` stays 1, and the stored key is unchanged for the running block and for later blocks.
- R10: When `keyLoad` and `start` are high at the same edge while idle, the key load takes effect and the start is ignored.
- R11: The mode is sampled only at the accepting edge. Changing `decrypt` while `busy` does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| keyLoad | input | 1 | Strobe: capture `keyIn` and start expansion |
| keyIn | input | 128 | Cipher key |
| keyReady | output | 1 | All eleven round keys are available |
| start | input | 1 | Strobe: accept `blockIn` and `decrypt` |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| blockIn | input | 128 | Input block |
| blockOut | output | 128 | Result block, valid from `done` on |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
On every cycle, the embedded assertions check the cycle bookkeeping:
- `done` is a single-cycle pulse that follows the round-10 cycle;
- the round counter advances by one while busy;
- the mode stays frozen during a block;
- a block is accepted only with a ready key;
- `keyReady` appears only once expansion has finished and persists until the next load.

Only the bench scenarios can show that the data itself is right. These cover:
- the published vectors in both directions;
- decrypt-of-encrypt round trips on random keys and blocks;
- a result that survives a stray `start`, key load or mode change in the middle of a run.

// File: rtl/aes_pkg.sv
`timescale 1ns/1ps
package aes_pkg;
  localparam int BLOCK_BITS = 128;
  localparam int NUM_ROUNDS = 10;
  localparam int NUM_KEYS   = NUM_ROUNDS + 1;
  localparam int RIDX_W     = $clog2(NUM_KEYS + 1);

  typedef logic [BLOCK_BITS-1:0] block_t;

  // strobes from the control unit to the datapath and key store
  typedef struct packed {
    logic              loadKey;
    logic              loadBlock;
    logic              runRound;
    logic              lastRound;
    logic              decMode;
    logic [RIDX_W-1:0] keyIdx;
  } ctrlStrobes_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    logic [7:0] expo;
    res  = 8'h01;
    base = a;
    expo = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (expo[i]) res = gfMul(res, base);
      base = gfMul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int k);
    logic [15:0] d;
    d = {a, a};
    return d[15-k -: 8];
  endfunction

  // forward substitution table entry, derived rather than listed
  function automatic logic [7:0] sboxFwd(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  // inverse substitution: undo the affine map, then invert
  function automatic logic [7:0] sboxInv(input logic [7:0] a);
    return gfInv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  // One xtime tree serves both directions: the inverse matrix equals the
  // forward one applied after a cheap preconditioning step.
  function automatic logic [31:0] mixColumn(input logic [31:0] col, input logic inv);
    logic [7:0] a0, a1, a2, a3, u, v, t;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    u  = xtime(xtime(a0 ^ a2));
    v  = xtime(xtime(a1 ^ a3));
    if (inv) begin
      a0 = a0 ^ u;
      a1 = a1 ^ v;
      a2 = a2 ^ u;
      a3 = a3 ^ v;
    end
    t = a0 ^ a1 ^ a2 ^ a3;
    return {a0 ^ t ^ xtime(a0 ^ a1), a1 ^ t ^ xtime(a1 ^ a2),
            a2 ^ t ^ xtime(a2 ^ a3), a3 ^ t ^ xtime(a3 ^ a0)};
  endfunction
endpackage

// File: rtl/aes_keysched.sv
`timescale 1ns/1ps
module aes_keysched
  import aes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadKey,
  input  block_t            keyIn,
  input  logic [RIDX_W-1:0] rdIdx,
  output block_t            roundKey,
  output logic              keyReady
);
  block_t            rkMem [NUM_KEYS];
  logic [RIDX_W-1:0] wrIdx;
  logic              expanding;
  logic [7:0]        rcon;
  block_t            prevKey;
  block_t            nextKey;
  logic [31:0]       lastWord;
  logic [31:0]       rotWord;
  logic [31:0]       mixWord;

  assign prevKey  = rkMem[wrIdx - 1'b1];
  assign lastWord = prevKey[31:0];
  assign rotWord  = {lastWord[23:0], lastWord[31:24]};

  always_comb begin
    mixWord = {sboxFwd(rotWord[31:24]), sboxFwd(rotWord[23:16]),
               sboxFwd(rotWord[15:8]),  sboxFwd(rotWord[7:0])} ^ {rcon, 24'h0};
    nextKey[127:96] = prevKey[127:96] ^ mixWord;
    nextKey[95:64]  = prevKey[95:64]  ^ nextKey[127:96];
    nextKey[63:32]  = prevKey[63:32]  ^ nextKey[95:64];
    nextKey[31:0]   = prevKey[31:0]   ^ nextKey[63:32];
  end

  always_ff @(posedge clk) begin
    if (loadKey) rkMem[0] <= keyIn;
    else if (expanding) rkMem[wrIdx] <= nextKey;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx     <= RIDX_W'(1);
      expanding <= 1'b0;
      rcon      <= 8'h01;
      keyReady  <= 1'b0;
    end else if (loadKey) begin
      wrIdx     <= RIDX_W'(1);
      expanding <= 1'b1;
      rcon      <= 8'h01;
      keyReady  <= 1'b0;
    end else if (expanding) begin
      wrIdx <= wrIdx + 1'b1;
      rcon  <= xtime(rcon);
      if (wrIdx == RIDX_W'(NUM_ROUNDS)) begin
        expanding <= 1'b0;
        keyReady  <= 1'b1;
      end
    end
  end

  assign roundKey = rkMem[rdIdx];

  // R2: readiness only after the last round key has been written
  a_r2_ready_after_expand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keyReady) |-> ($past(expanding) && wrIdx == RIDX_W'(NUM_KEYS)));
  // R2: never ready while expansion is still running
  a_r2_not_ready_expanding: assert property (@(posedge clk) disable iff (!rst_n)
    expanding |-> !keyReady);
  // R9: a ready key stays ready until a load is accepted
  a_r9_ready_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (keyReady && !loadKey) |=> keyReady);
  // R4: the read index always addresses a stored round key
  a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rdIdx < RIDX_W'(NUM_KEYS));
endmodule

// File: rtl/aes_datapath.sv
`timescale 1ns/1ps
module aes_datapath
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t strobes,
  input  block_t       blockIn,
  input  block_t       roundKey,
  output block_t       stateOut
);
  block_t stateQ;
  block_t shifted;
  block_t subbed;
  block_t preMix;
  block_t mixed;
  block_t mixOut;
  block_t roundOut;
  logic   unusedBits;

  assign unusedBits = ^{strobes.keyIdx, strobes.loadKey};

  // Row shift (pure wiring) then substitution; the two commute, so one order
  // serves encryption and decryption alike.
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST   = 4 * c + r;
      localparam int SRC_E = 4 * ((c + r) % 4) + r;
      localparam int SRC_D = 4 * ((c + 4 - r) % 4) + r;
      assign shifted[127-8*DST -: 8] = strobes.decMode ? stateQ[127-8*SRC_D -: 8]
                                                       : stateQ[127-8*SRC_E -: 8];
      assign subbed[127-8*DST -: 8]  = strobes.decMode ? sboxInv(shifted[127-8*DST -: 8])
                                                       : sboxFwd(shifted[127-8*DST -: 8]);
    end
    assign mixed[127-32*c -: 32] = mixColumn(preMix[127-32*c -: 32], strobes.decMode);
  end

  // decrypt adds the key before mixing, encrypt after
  assign preMix   = strobes.decMode ? (subbed ^ roundKey) : subbed;
  assign mixOut   = strobes.lastRound ? preMix : mixed;
  assign roundOut = strobes.decMode ? mixOut : (mixOut ^ roundKey);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stateQ <= '0;
    else if (strobes.loadBlock) stateQ <= blockIn ^ roundKey;
    else if (strobes.runRound)  stateQ <= roundOut;
  end

  assign stateOut = stateQ;

  // R8: without a load or a round the result register does not move
  a_r8_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.loadBlock && !strobes.runRound) |=> $stable(stateQ));
endmodule

// File: rtl/aes_ctrl.sv
`timescale 1ns/1ps
module aes_ctrl
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         decrypt,
  input  logic         keyLoad,
  input  logic         keyReady,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NUM_ROUNDS);

  logic [RIDX_W-1:0] round;
  logic              decQ;
  logic              accept;

  // a key load wins over a simultaneous start
  assign accept = start && !busy && keyReady && !keyLoad;

  always_comb begin
    strobes.loadKey   = keyLoad && !busy;
    strobes.loadBlock = accept;
    strobes.runRound  = busy;
    strobes.lastRound = (round == LAST_IDX);
    strobes.decMode   = accept ? decrypt : decQ;
    if (accept) strobes.keyIdx = decrypt ? LAST_IDX : '0;
    else        strobes.keyIdx = decQ ? (LAST_IDX - round) : round;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      round <= '0;
      decQ  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        round <= RIDX_W'(1);
        decQ  <= decrypt;
      end else if (busy) begin
        if (round == LAST_IDX) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          round <= '0;
        end else begin
          round <= round + 1'b1;
        end
      end
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: the last round is followed by done and by leaving busy
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && round == LAST_IDX) |=> (done && !busy));
  // R6: while busy the round count only steps forward by one
  a_r6_round_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && round != LAST_IDX) |=> (busy && round == $past(round) + 1'b1));
  // R2: a block is only accepted with a ready key
  a_r2_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(keyReady));
  // R11: the mode is frozen for the whole block
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(decQ));
endmodule

// File: rtl/aes_core.sv
`timescale 1ns/1ps
module aes_core
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         keyLoad,
  input  logic [127:0] keyIn,
  output logic         keyReady,
  input  logic         start,
  input  logic         decrypt,
  input  logic [127:0] blockIn,
  output logic [127:0] blockOut,
  output logic         busy,
  output logic         done
);
  ctrlStrobes_t strobes;
  block_t       roundKey;

  aes_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .keyLoad(keyLoad), .keyReady(keyReady), .strobes(strobes),
    .busy(busy), .done(done)
  );

  aes_keysched u_keys (
    .clk(clk), .rst_n(rst_n), .loadKey(strobes.loadKey), .keyIn(keyIn),
    .rdIdx(strobes.keyIdx), .roundKey(roundKey), .keyReady(keyReady)
  );

  aes_datapath u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .blockIn(blockIn),
    .roundKey(roundKey), .stateOut(blockOut)
  );
endmodule

// File: tb/aes_core_test.sv
`timescale 1ns/1ps
module aes_core_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         keyReady;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] blockIn = '0;
  logic [127:0] blockOut;
  logic         busy;
  logic         done;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  aes_core uut (
    .clk(clk), .rst_n(rst_n), .keyLoad(keyLoad), .keyIn(keyIn),
    .keyReady(keyReady), .start(start), .decrypt(decrypt),
    .blockIn(blockIn), .blockOut(blockOut), .busy(busy), .done(done)
  );

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // load a key; returns edges until keyReady, optionally probing a start
  task automatic loadKeyTask(input logic [127:0] k, input bit probe, output int lat);
    @(negedge clk);
    keyLoad = 1'b1;
    keyIn   = k;
    @(negedge clk);
    keyLoad = 1'b0;
    lat     = -1;
    for (int i = 1; i <= 30; i++) begin
      if (probe && i == 3) begin start = 1'b1; blockIn = P1; end
      @(negedge clk);
      if (probe && i == 3) begin
        start = 1'b0;
        check(busy == 1'b0, "R2 start ignored while key not ready", 128'(busy), 128'd0);
      end
      if (keyReady) begin lat = i; break; end
    end
  endtask

  // disturb: 0 none, 1 extra start, 2 key load, 3 flip decrypt mid-run
  task automatic runBlock(input bit dec, input logic [127:0] din, input int disturb,
                          output logic [127:0] dout, output int lat);
    @(negedge clk);
    start   = 1'b1;
    decrypt = dec;
    blockIn = din;
    @(negedge clk);
    start   = 1'b0;
    blockIn = rnd128();
    lat     = -1;
    dout    = '0;
    for (int i = 1; i <= 20; i++) begin
      if (i == 3 && disturb == 1) begin start = 1'b1; blockIn = ~din; end
      if (i == 3 && disturb == 2) begin keyLoad = 1'b1; keyIn = rnd128(); end
      if (i == 3 && disturb == 3) decrypt = ~dec;
      @(negedge clk);
      if (i == 3) begin start = 1'b0; keyLoad = 1'b0; end
      if (done) begin lat = i; dout = blockOut; break; end
    end
    decrypt = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nFails++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stimulus
    logic [127:0] res;
    logic [127:0] res2;
    int lat;

    repeat (3) @(negedge clk);
    check({busy, done, keyReady} == 3'b000, "R1 reset outputs", 128'({busy, done, keyReady}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, keyReady} == 3'b000, "R1 idle after reset", 128'({busy, done, keyReady}), 128'd0);

    loadKeyTask(K1, 1'b1, lat);
    check(lat == 10, "R2 keyReady latency", 128'(lat), 128'd10);

    // R3 encrypt, R5 timing, R8 hold
    runBlock(1'b0, P1, 0, res, lat);
    check(res == C1, "R3 encrypt vector 1", res, C1);
    check(lat == 10, "R5 done latency encrypt", 128'(lat), 128'd10);
    @(negedge clk);
    check({done, busy} == 2'b00, "R5 done single cycle", 128'({done, busy}), 128'd0);
    repeat (3) @(negedge clk);
    check(blockOut == C1, "R8 result held", blockOut, C1);

    runBlock(1'b1, C1, 0, res, lat);
    check(res == P1, "R4 decrypt vector 1", res, P1);
    check(lat == 10, "R5 done latency decrypt", 128'(lat), 128'd10);

    runBlock(1'b0, P1, 1, res, lat);
    check(res == C1 && lat == 10, "R6 start while busy ignored", res, C1);

    runBlock(1'b0, P1, 3, res, lat);
    check(res == C1, "R11 mode flip during encrypt", res, C1);
    runBlock(1'b1, C1, 3, res, lat);
    check(res == P1, "R11 mode flip during decrypt", res, P1);

    runBlock(1'b0, P1, 2, res, lat);
    check(res == C1, "R9 key load while busy ignored", res, C1);
    check(keyReady == 1'b1, "R9 keyReady kept", 128'(keyReady), 128'd1);
    runBlock(1'b0, P1, 0, res, lat);
    check(res == C1, "R9 key unchanged afterwards", res, C1);

    // R10: simultaneous load and start
    @(negedge clk);
    keyLoad = 1'b1; keyIn = K2; start = 1'b1; blockIn = P2;
    @(negedge clk);
    keyLoad = 1'b0; start = 1'b0;
    check({busy, keyReady} == 2'b00, "R10 load wins over start", 128'({busy, keyReady}), 128'd0);
    repeat (12) @(negedge clk);
    check(keyReady == 1'b1, "R10 new key ready", 128'(keyReady), 128'd1);
    runBlock(1'b0, P2, 0, res, lat);
    check(res == C2, "R3 encrypt vector 2", res, C2);
    runBlock(1'b1, C2, 0, res, lat);
    check(res == P2, "R4 decrypt vector 2", res, P2);

    // R7 round trips under random keys
    for (int k = 0; k < 4; k++) begin
      loadKeyTask(rnd128(), 1'b0, lat);
      check(lat == 10, "R2 keyReady latency random key", 128'(lat), 128'd10);
      for (int b = 0; b < 40; b++) begin
        logic [127:0] x;
        x = rnd128();
        runBlock(1'b0, x, 0, res, lat);
        check(lat == 10, "R5 latency random", 128'(lat), 128'd10);
        runBlock(1'b1, res, 0, res2, lat);
        check(res2 == x, "R7 decrypt of encrypt", res2, x);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule